// File: doc/BRIEF.md
# Rotating-Coefficient Correlation Array

This block computes a sliding correlation of a short coefficient sequence against an unbounded stream of signed samples. For tap count `NTAP`, output number n is the sum over l = 0 .. NTAP-1 of `coef[l] * x[n+l]`. The coefficients are written once over a small load port. After that, the block takes one sample per accepted step and, once the pipeline is full, returns one finished correlation value per accepted sample.

The structure has layers. A coefficient ring holds one coefficient above each accumulating cell and rotates by one position per accepted sample. Coefficient 0 carries a one-bit head marker. Each incoming sample is broadcast to every cell. Each cell multiplies the coefficient above it by the sample and adds the product to its running sum. When the head marker reaches a cell, that cell hands its finished sum to the output stage and restarts its sum from the new product. Exactly one cell holds the marker in any step, so finished values leave at one per step and in increasing order of n.

Top module: `corr_ring_array`

## Requirements
- R1: After reset, `y_valid` is 0 and stays 0 until at least NTAP samples have been accepted after a coefficient load.
- R2: A cycle with `wt_load` = 1 writes `wt_data` as coefficient number `wt_idx` (0 .. NTAP-1). It clears all partial sums, and it drops any sample offered in the same cycle. `y_valid` is 0 in the cycle after a load. Sample counting restarts at 0 after a load.
- R3: Number accepted samples from 0 after the last load. `y_valid` is 1 for exactly one cycle right after sample t is accepted (`x_valid` = 1, `wt_load` = 0) when t >= NTAP, and 0 otherwise.
- R4: The value presented with the output that follows sample t = n + NTAP is the sum over l of coef[l] * x[n+l]. It is computed with full 32-bit products and a 36-bit signed sum.
- R5: Successive outputs carry c0, c1, c2, ... with no value skipped or repeated. The same cell that emits a value starts the next value in that cell in the same cycle, and no product is lost.
- R6: A cycle with `x_valid` = 0 and `wt_load` = 0 produces no output and changes no ring or sum state. The stream resumes with correct values afterwards.
- R7: Full-scale operands (-32768 and 32767 in every coefficient and sample) accumulate exactly, with no wrap.
- R8: Reloading all coefficients in the middle of a stream discards the old partial sums. The values produced after the reload use only the new coefficients and the samples accepted after the reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wt_load | input | 1 | Coefficient write strobe |
| wt_idx | input | 2 | Coefficient number being written |
| wt_data | input | 16 | Signed coefficient value |
| x_valid | input | 1 | Sample present this cycle |
| x_data | input | 16 | Signed sample |
| y_valid | output | 1 | Correlation value present (one cycle) |
| y_data | output | 36 | Signed correlation value |

## Verification
In every productive step, one cell finishes output n and seeds output n + NTAP in the same cycle. That is the point where a lost or doubled product would appear. The bench drives back-to-back samples with random coefficients, so the handoff happens on every cycle. It judges both the emitted value and the value that the same cell emits NTAP samples later against a reference sum. Stall cycles and mid-stream reloads are mixed in to move the handoff relative to the load. Offering a sample in the same cycle as a load checks that the load wins.

// File: rtl/corr_pkg.sv
package corr_pkg;
    localparam int unsigned CORR_NTAP = 4;
    localparam int unsigned CORR_DW   = 16;
    localparam int unsigned CORR_AW   = 36;
endpackage

// File: rtl/corr_weight_ring.sv
module corr_weight_ring #(
    parameter int unsigned NTAP = 4,
    parameter int unsigned DW   = 16,
    parameter int unsigned IW   = (NTAP > 1) ? $clog2(NTAP) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load_en,
    input  logic [IW-1:0]             load_idx,
    input  logic [DW-1:0]             load_data,
    input  logic                      adv,
    output logic [NTAP-1:0][DW-1:0]   w_o,
    output logic [NTAP-1:0]           mark_o
);
    typedef struct packed {
        logic [NTAP-1:0][DW-1:0] w;
        logic [NTAP-1:0]         mark;
    } ring_t;

    ring_t         ring_d, ring_q;
    logic [IW-1:0] slot;

    // coefficient i lands under cell (NTAP - i) mod NTAP, so cell j sees coef[-j] first
    always_comb begin
        slot = (load_idx == '0) ? '0 : IW'(NTAP - int'(load_idx));
    end

    always_comb begin
        ring_d = ring_q;
        if (load_en) begin
            ring_d.mark    = '0;
            ring_d.mark[0] = 1'b1;
            if (int'(load_idx) < int'(NTAP)) begin
                ring_d.w[slot] = load_data;
            end
        end else if (adv) begin
            for (int j = 0; j < int'(NTAP); j++) begin
                ring_d.w[j]    = ring_q.w[(j + int'(NTAP) - 1) % int'(NTAP)];
                ring_d.mark[j] = ring_q.mark[(j + int'(NTAP) - 1) % int'(NTAP)];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ring_q.w    <= '0;
            ring_q.mark <= NTAP'(1);
        end else begin
            ring_q <= ring_d;
        end
    end

    assign w_o    = ring_q.w;
    assign mark_o = ring_q.mark;

    // R6: an idle cycle leaves the ring untouched
    a_r6_ring_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !adv) |=> ($stable(ring_q.w) && $stable(ring_q.mark)));
endmodule

// File: rtl/corr_acc_cell.sv
module corr_acc_cell #(
    parameter int unsigned DW = 16,
    parameter int unsigned AW = 36
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_i,
    input  logic                 step_i,
    input  logic [DW-1:0]        w_i,
    input  logic                 mark_i,
    input  logic [DW-1:0]        x_i,
    output logic signed [AW-1:0] acc_o,
    output logic                 dump_o
);
    localparam int unsigned PW = 2 * DW;

    typedef struct packed {
        logic signed [AW-1:0] acc;
        logic                 primed;
    } cell_t;

    cell_t                cell_d, cell_q;
    logic signed [PW-1:0] prod;
    logic signed [AW-1:0] prod_ext;

    always_comb begin
        prod     = $signed(w_i) * $signed(x_i);
        prod_ext = {{(AW - PW){prod[PW-1]}}, prod};
        cell_d   = cell_q;
        if (clr_i) begin
            cell_d = '0;
        end else if (step_i) begin
            if (mark_i) begin
                cell_d.acc    = prod_ext;
                cell_d.primed = 1'b1;
            end else begin
                cell_d.acc = cell_q.acc + prod_ext;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cell_q <= '0;
        end else begin
            cell_q <= cell_d;
        end
    end

    assign acc_o  = cell_q.acc;
    assign dump_o = step_i && !clr_i && mark_i && cell_q.primed;

    // R5: a head-marker step always leaves the cell holding a live sum
    a_r5_restart_primed: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !clr_i && mark_i) |=> cell_q.primed);
    // R2: a load wipes the partial sum
    a_r2_clear_sum: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cell_q.acc == '0 && !cell_q.primed));
endmodule

// File: rtl/corr_out_pick.sv
module corr_out_pick #(
    parameter int unsigned NTAP = 4,
    parameter int unsigned AW   = 36
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NTAP-1:0]            dump_i,
    input  logic [NTAP-1:0][AW-1:0]    acc_i,
    output logic                       valid_o,
    output logic [AW-1:0]              data_o
);
    typedef struct packed {
        logic          valid;
        logic [AW-1:0] data;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d       = out_q;
        out_d.valid = |dump_i;
        for (int j = 0; j < int'(NTAP); j++) begin
            if (dump_i[j]) begin
                out_d.data = acc_i[j];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign valid_o = out_q.valid;
    assign data_o  = out_q.data;

    // R5: never two finished sums in one step
    a_r5_single_dump: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dump_i));
endmodule

// File: rtl/corr_ring_array.sv
module corr_ring_array
    import corr_pkg::*;
#(
    parameter int unsigned NTAP = CORR_NTAP,
    parameter int unsigned DW   = CORR_DW,
    parameter int unsigned AW   = CORR_AW,
    localparam int unsigned IW  = (NTAP > 1) ? $clog2(NTAP) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wt_load,
    input  logic [IW-1:0] wt_idx,
    input  logic [DW-1:0] wt_data,
    input  logic          x_valid,
    input  logic [DW-1:0] x_data,
    output logic          y_valid,
    output logic [AW-1:0] y_data
);
    logic                    step;
    logic [NTAP-1:0][DW-1:0] ring_w;
    logic [NTAP-1:0]         ring_mark;
    logic [NTAP-1:0][AW-1:0] cell_acc;
    logic [NTAP-1:0]         cell_dump;

    assign step = x_valid && !wt_load;

    corr_weight_ring #(.NTAP(NTAP), .DW(DW), .IW(IW)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (wt_load),
        .load_idx  (wt_idx),
        .load_data (wt_data),
        .adv       (step),
        .w_o       (ring_w),
        .mark_o    (ring_mark)
    );

    for (genvar j = 0; j < int'(NTAP); j++) begin : g_cell
        logic signed [AW-1:0] acc_s;
        corr_acc_cell #(.DW(DW), .AW(AW)) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr_i  (wt_load),
            .step_i (step),
            .w_i    (ring_w[j]),
            .mark_i (ring_mark[j]),
            .x_i    (x_data),
            .acc_o  (acc_s),
            .dump_o (cell_dump[j])
        );
        assign cell_acc[j] = acc_s;
    end

    corr_out_pick #(.NTAP(NTAP), .AW(AW)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .dump_i  (cell_dump),
        .acc_i   (cell_acc),
        .valid_o (y_valid),
        .data_o  (y_data)
    );

    // R3: a result only follows an accepted sample
    a_r3_out_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
        y_valid |-> $past(x_valid && !wt_load));
    // R2: the cycle after a load is silent
    a_r2_load_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        wt_load |=> !y_valid);
    // R6: a stall cycle emits nothing
    a_r6_stall_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!x_valid && !wt_load) |=> !y_valid);
endmodule

// File: tb/tb_corr_ring_array.sv
module tb_corr_ring_array;
    localparam int N  = 4;
    localparam int DW = 16;
    localparam int AW = 36;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wt_load;
    logic [IW-1:0] wt_idx;
    logic [DW-1:0] wt_data;
    logic          x_valid;
    logic [DW-1:0] x_data;
    logic          y_valid;
    logic [AW-1:0] y_data;

    always #5 clk = ~clk;

    corr_ring_array dut (
        .clk(clk), .rst_n(rst_n), .wt_load(wt_load), .wt_idx(wt_idx),
        .wt_data(wt_data), .x_valid(x_valid), .x_data(x_data),
        .y_valid(y_valid), .y_data(y_data)
    );

    int wt [N];
    int xs [0:4095];
    int t;
    int n_chk;
    int n_fail;
    bit done;

    function automatic longint ref_corr(int n);
        longint s = 0;
        for (int l = 0; l < N; l++) s += longint'(wt[l]) * longint'(xs[n + l]);
        return s;
    endfunction

    function automatic int rnd16();
        return int'($urandom_range(65535)) - 32768;
    endfunction

    task automatic chk(bit ok, string req, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load_all(int w0, int w1, int w2, int w3);
        int v [N];
        v[0] = w0; v[1] = w1; v[2] = w2; v[3] = w3;
        for (int i = 0; i < N; i++) begin
            wt_load = 1'b1;
            wt_idx  = IW'(i);
            wt_data = DW'(v[i]);
            x_valid = 1'($urandom_range(1));   // R2: offered sample must be dropped
            x_data  = DW'(rnd16());
            @(posedge clk); @(negedge clk);
            wt[i] = v[i];
            chk(!y_valid, "R2 quiet during load", longint'(y_valid), 0);
        end
        wt_load = 1'b0;
        x_valid = 1'b0;
        t = 0;
    endtask

    task automatic do_step(bit v, int x, string req);
        logic signed [AW-1:0] e36;
        longint e;
        x_valid = v;
        x_data  = DW'(x);
        @(posedge clk); @(negedge clk);
        x_valid = 1'b0;
        if (v) begin
            xs[t] = x;
            if (t >= N) begin
                e   = ref_corr(t - N);
                e36 = AW'(e);
                chk(y_valid == 1'b1, {"R3 valid ", req}, longint'(y_valid), 1);
                chk(y_data == e36, {"R4 R5 value ", req},
                    longint'($signed(y_data)), longint'(e36));
            end else begin
                chk(!y_valid, {"R3 fill ", req}, longint'(y_valid), 0);
            end
            t++;
        end else begin
            chk(!y_valid, "R6 stall", longint'(y_valid), 0);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd19870815));
        n_chk = 0; n_fail = 0; done = 0; t = 0;
        rst_n = 1'b0; wt_load = 1'b0; wt_idx = '0; wt_data = '0;
        x_valid = 1'b0; x_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!y_valid, "R1 reset", longint'(y_valid), 0);

        // directed ramp
        load_all(1, 2, 3, 4);
        for (int i = 1; i <= 12; i++) do_step(1'b1, i, "ramp");

        // random coefficients, random samples, random stalls
        load_all(rnd16(), rnd16(), rnd16(), rnd16());
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(3) == 0) do_step(1'b0, 0, "R6");
            else                        do_step(1'b1, rnd16(), "random");
        end

        // full-scale negative times negative
        load_all(-32768, -32768, -32768, -32768);
        for (int i = 0; i < 10; i++) do_step(1'b1, -32768, "R7 neg");

        // full-scale mixed signs
        load_all(32767, -32768, 32767, -32768);
        for (int i = 0; i < 10; i++) do_step(1'b1, (i % 2 == 0) ? -32768 : 32767, "R7 mix");

        // reload in the middle of a stream
        load_all(rnd16(), rnd16(), rnd16(), rnd16());
        for (int i = 0; i < 7; i++) do_step(1'b1, rnd16(), "pre R8");
        load_all(rnd16(), rnd16(), rnd16(), rnd16());
        for (int i = 0; i < 60; i++) do_step(1'b1, rnd16(), "R8 reload");

        // stalls right around the first output
        load_all(5, -7, 11, -13);
        for (int i = 0; i < 3; i++) do_step(1'b1, rnd16(), "R6 fill");
        do_step(1'b0, 0, "R6");
        do_step(1'b0, 0, "R6");
        for (int i = 0; i < 8; i++) do_step(1'b1, rnd16(), "R6 resume");

        done = 1;
        summary();
        $finish;
    end
endmodule